// File: doc/BRIEF.md
# ADC hardware trigger gate

This block decides when a hardware event may start an A/D conversion. It chooses one of three trigger sources with a 2-bit source field: a start pin outside the chip, a timer-overflow pulse, or a PWM trigger pulse. It emits a one-cycle `start_req` that the converter sequencer uses to set its start bit.

The start pin is first brought into the clock domain by a two-flop synchronizer. A 2-bit condition field then sets the pin event to a low level, a high level, a falling edge or a rising edge. A level is accepted only after it has held for `LEVEL_HOLD` clocks. An edge is accepted only if the new state then holds for `EDGE_HOLD` clocks. Timer and PWM pulses are taken on their rising edge.

Hardware triggering works only when the enable input is set and the operating mode is single-cycle scan. An event that arrives while the start bit is already set is dropped, not queued. The source field may change only while the enable input and the start bit are both 0.

Top module: `adc_hw_trigger_gate`

## Requirements
- R1: `start_req` is 0 during reset and stays 0 after reset until a qualifying event occurs.
- R2: No request is produced unless `trig_en` is 1 and `op_mode` is 2'b10 (single-cycle scan). The other mode codes 00, 01 and 11 block every source.
- R3: With `trig_src` = 2'b01, a rising edge of `timer_pulse` sampled on a clock edge makes `start_req` high for the cycle after that edge. `pwm_pulse` is ignored.
- R4: With `trig_src` = 2'b11, a rising edge of `pwm_pulse` makes `start_req` high for the cycle after that edge. `timer_pulse` is ignored.
- R5: With `trig_src` = 2'b10 (reserved), no request is ever produced.
- R6: With `trig_src` = 2'b00 and `trig_cond` = 2'b00 (low) or 2'b01 (high), suppose the pin changes to the active level after clock edge 0 and holds at least `LEVEL_HOLD` cycles. Then `start_req` is high after edge `LEVEL_HOLD`+2. If the level holds only `LEVEL_HOLD`-1 cycles, no request is produced. A change toward the inactive level produces nothing.
- R7: With `trig_src` = 2'b00 and `trig_cond` = 2'b10 (falling) or 2'b11 (rising), suppose the pin makes that transition after clock edge 0 and the new state holds at least `EDGE_HOLD` cycles. Then `start_req` is high after edge `EDGE_HOLD`+2. That happens once per transition, however long the state then lasts. If the state holds only `EDGE_HOLD`-1 cycles, or the transition goes the other way, no request is produced.
- R8: While `start_busy` is 1, trigger events from any source are dropped. After `start_busy` returns to 0, no request for those events is issued.
- R9: Under a level condition a held active level produces a further request only after `LEVEL_HOLD` consecutive clock edges that sample `start_busy` low with no request in between. Thus a level held with `start_busy` low repeats every `LEVEL_HOLD` cycles.
- R10: `start_req` is never high for two consecutive cycles. A timer pulse held high for several cycles gives one request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_en | input | 1 | Hardware trigger enable |
| op_mode | input | 2 | Converter operating mode. Only 2'b10 (single-cycle scan) allows triggering |
| trig_src | input | 2 | Source: 00 pin, 01 timer, 10 reserved, 11 PWM |
| trig_cond | input | 2 | Pin event: 00 low, 01 high, 10 falling, 11 rising |
| pin_async | input | 1 | Start pin, not yet synchronized |
| timer_pulse | input | 1 | Timer overflow pulse |
| pwm_pulse | input | 1 | PWM trigger pulse |
| start_busy | input | 1 | Current value of the converter start bit |
| start_req | output | 1 | One-cycle request to set the start bit |

## Verification
On every cycle the assertions check four properties of each request. It lasts one cycle. It came from an enabled, scan-mode, non-reserved setting while the start bit was clear. A timer-sourced request had the timer pulse high on the cycle before. A pin-sourced request had the synchronized pin at the active value for at least the level or edge hold length. Only the bench's scenarios show the exact request latencies and the glitch boundaries (hold minus one rejected, hold accepted). They also show that dropped events are never replayed and that a held level repeats at the right period after the start bit clears. Those are statements about events that must occur, not only about requests that do occur.

// File: rtl/adc_hw_trigger_gate.sv
module adc_hw_trigger_gate #(
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_en,
  input  logic [1:0] op_mode,
  input  logic [1:0] trig_src,
  input  logic [1:0] trig_cond,
  input  logic       pin_async,
  input  logic       timer_pulse,
  input  logic       pwm_pulse,
  input  logic       start_busy,
  output logic       start_req
);
  localparam int LW = $clog2(LEVEL_HOLD + 1);
  localparam int EW = $clog2(EDGE_HOLD + 1);
  localparam logic [1:0] MODE_SCAN = 2'b10;

  logic [SYNC_STAGES-1:0] sync;
  logic          pin_s, pin_pre;
  logic [LW-1:0] lvl_cnt;
  logic [EW-1:0] edge_cnt;
  logic          moved, tmr_q, pwm_q;
  logic          pin_hit, pick, fire;

  assign pin_s   = sync[SYNC_STAGES-1];
  assign pin_pre = sync[SYNC_STAGES-2];

  wire moving   = pin_pre != pin_s;
  wire active   = pin_s == trig_cond[0];
  wire armed    = trig_en && (op_mode == MODE_SCAN) && !start_busy;
  wire lvl_hit  = !trig_cond[1] && active && (lvl_cnt == LW'(LEVEL_HOLD - 1));
  wire edge_hit = trig_cond[1] && active && moved && (edge_cnt == EW'(EDGE_HOLD - 1));

  assign pin_hit = lvl_hit || edge_hit;

  always_comb begin
    case (trig_src)
      2'b00:   pick = pin_hit;
      2'b01:   pick = timer_pulse && !tmr_q;
      2'b11:   pick = pwm_pulse && !pwm_q;
      default: pick = 1'b0;
    endcase
  end

  assign fire = armed && pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= '0;
      tmr_q     <= 1'b0;
      pwm_q     <= 1'b0;
      moved     <= 1'b0;
      edge_cnt  <= '0;
      lvl_cnt   <= '0;
      start_req <= 1'b0;
    end else begin
      sync      <= {sync[SYNC_STAGES-2:0], pin_async};
      tmr_q     <= timer_pulse;
      pwm_q     <= pwm_pulse;
      start_req <= fire;
      if (moving) moved <= 1'b1;
      if (moving)
        edge_cnt <= '0;
      else if (edge_cnt < EW'(EDGE_HOLD))
        edge_cnt <= edge_cnt + 1'b1;
      if (moving || start_busy || fire)
        lvl_cnt <= '0;
      else if (lvl_cnt < LW'(LEVEL_HOLD - 1))
        lvl_cnt <= lvl_cnt + 1'b1;
    end
  end
endmodule

module adc_hw_trigger_gate_chk #(
  parameter int LEVEL_HOLD = 8,
  parameter int EDGE_HOLD  = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_en,
  input logic [1:0] op_mode,
  input logic [1:0] trig_src,
  input logic [1:0] trig_cond,
  input logic       timer_pulse,
  input logic       start_busy,
  input logic       start_req,
  input logic       pin_s,
  input logic       pin_pre
);
  localparam int RW = $clog2(LEVEL_HOLD + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (pin_pre != pin_s) run <= '0;
    else if (run < RW'(LEVEL_HOLD)) run <= run + 1'b1;
  end

  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> !start_req);

  assert_gated_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(trig_en && op_mode == 2'b10));

  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> $past(trig_src != 2'b10));

  assert_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> !$past(start_busy));

  assert_timer_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && $past(trig_src == 2'b01)) |-> $past(timer_pulse));

  assert_level_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && $past(trig_src == 2'b00 && !trig_cond[1]))
      |-> $past(pin_s == trig_cond[0] && run >= RW'(LEVEL_HOLD - 1)));

  assert_edge_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && $past(trig_src == 2'b00 && trig_cond[1]))
      |-> $past(pin_s == trig_cond[0] && run >= RW'(EDGE_HOLD - 1)));
endmodule

bind adc_hw_trigger_gate adc_hw_trigger_gate_chk #(
  .LEVEL_HOLD(LEVEL_HOLD),
  .EDGE_HOLD (EDGE_HOLD)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_en    (trig_en),
  .op_mode    (op_mode),
  .trig_src   (trig_src),
  .trig_cond  (trig_cond),
  .timer_pulse(timer_pulse),
  .start_busy (start_busy),
  .start_req  (start_req),
  .pin_s      (pin_s),
  .pin_pre    (pin_pre)
);

// File: tb/adc_hw_trigger_gate_bench.sv
module adc_hw_trigger_gate_bench;
  localparam int LH = 8;
  localparam int EH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_en = 1'b0;
  logic [1:0] op_mode = 2'b10;
  logic [1:0] trig_src = 2'b00;
  logic [1:0] trig_cond = 2'b11;
  logic       pin_async = 1'b0;
  logic       timer_pulse = 1'b0;
  logic       pwm_pulse = 1'b0;
  logic       start_busy = 1'b0;
  logic       start_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_hw_trigger_gate #(.LEVEL_HOLD(LH), .EDGE_HOLD(EH)) u_adc_hw_trigger_gate (
    .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .op_mode(op_mode),
    .trig_src(trig_src), .trig_cond(trig_cond), .pin_async(pin_async),
    .timer_pulse(timer_pulse), .pwm_pulse(pwm_pulse),
    .start_busy(start_busy), .start_req(start_req)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: start_req=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic watch(input int n, input int at1, input int at2, input string tag);
    for (int k = 1; k <= n; k++) begin
      step();
      chk(start_req, (k == at1) || (k == at2), tag);
    end
  endtask

  task automatic setup(input logic en, input logic [1:0] md, input logic [1:0] src,
                       input logic [1:0] cnd);
    trig_en = 1'b0;
    step();
    op_mode = md; trig_src = src; trig_cond = cnd;
    step();
    trig_en = en;
  endtask

  task automatic settle_pin(input logic v);
    trig_en = 1'b0;
    pin_async = v;
    repeat (LH + 4) step();
  endtask

  task automatic pin_pulse(input int n, input int at, input string tag);
    pin_async = ~pin_async;
    for (int k = 1; k <= n + LH + 4; k++) begin
      step();
      if (k == n) pin_async = ~pin_async;
      chk(start_req, k == at, tag);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) begin step(); chk(start_req, 1'b0, "R1 in reset"); end
    rst_n = 1'b1;
    watch(4, 0, 0, "R1 after reset");

    for (int en = 0; en < 2; en++)
      for (int md = 0; md < 4; md++)
        for (int src = 0; src < 4; src++) begin
          logic ok;
          setup(en[0], md[1:0], src[1:0], 2'b11);
          ok = en[0] && (md == 2);
          timer_pulse = 1'b1;
          step(); chk(start_req, ok && src == 1, "R2/R3/R5 timer");
          timer_pulse = 1'b0;
          watch(2, 0, 0, "R4 timer ignored");
          pwm_pulse = 1'b1;
          step(); chk(start_req, ok && src == 3, "R2/R4/R5 pwm");
          pwm_pulse = 1'b0;
          watch(2, 0, 0, "R3 pwm ignored");
        end

    setup(1'b1, 2'b10, 2'b01, 2'b11);
    timer_pulse = 1'b1;
    watch(4, 1, 0, "R10 long timer pulse");
    timer_pulse = 1'b0;
    watch(2, 0, 0, "R10 tail");

    for (int c = 0; c < 2; c++) begin
      setup(1'b0, 2'b10, 2'b00, c[1:0]);
      settle_pin(~c[0]);
      trig_en = 1'b1;
      pin_async = c[0];
      watch(2 * LH + 2, LH + 2, 2 * LH + 2, "R6/R9 held level");
      pin_async = ~c[0];
      watch(12, 0, 0, "R6 inactive change");
      pin_pulse(LH - 1, 0, "R6 short level");
      pin_pulse(LH, LH + 2, "R6 minimum level");
    end

    for (int c = 2; c < 4; c++) begin
      setup(1'b0, 2'b10, 2'b00, c[1:0]);
      settle_pin(~c[0]);
      trig_en = 1'b1;
      pin_async = c[0];
      watch(20, EH + 2, 0, "R7 edge once");
      pin_async = ~c[0];
      watch(12, 0, 0, "R7 opposite edge");
      pin_pulse(EH - 1, 0, "R7 short edge");
      pin_pulse(EH, EH + 2, "R7 minimum edge");
    end

    setup(1'b1, 2'b10, 2'b01, 2'b11);
    start_busy = 1'b1;
    timer_pulse = 1'b1;
    step(); chk(start_req, 1'b0, "R8 busy timer");
    timer_pulse = 1'b0;
    watch(2, 0, 0, "R8 busy timer");
    start_busy = 1'b0;
    watch(4, 0, 0, "R8 no replay timer");

    setup(1'b0, 2'b10, 2'b00, 2'b11);
    settle_pin(1'b0);
    trig_en = 1'b1;
    start_busy = 1'b1;
    pin_async = 1'b1;
    watch(EH + 4, 0, 0, "R8 busy edge");
    start_busy = 1'b0;
    watch(8, 0, 0, "R8 no replay edge");

    setup(1'b0, 2'b10, 2'b00, 2'b01);
    settle_pin(1'b0);
    trig_en = 1'b1;
    pin_async = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      step();
      chk(start_req, (k == LH + 2) || (k == LH + 2 + 5 + LH), "R9 level after busy");
      if (k == LH + 2) start_busy = 1'b1;
      if (k == LH + 2 + 5) start_busy = 1'b0;
    end
    start_busy = 1'b1;
    trig_en = 1'b0;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule